// File: doc/BRIEF.md
# Dual-Threshold Strip Cluster Finder

The block scans one readout chip's worth of baseline-corrected strip amplitudes, one strip per accepted beat, each with its own noise figure. It keeps two kinds of hit. The first is a run of adjacent strips that all clear a low signal-to-noise cut. The second is a lone strip that clears a stricter cut. Every kept cluster becomes a short byte record on the write side of an on-chip FIFO. The record holds the position of its first strip within the chip, its width, and one saturated 8-bit amplitude per strip.

The signal-to-noise cut uses no divider. A strip passes when four times its signal is strictly greater than the threshold multiplied by the strip's noise, so each threshold is an unsigned value with two fractional bits. Both thresholds are plain inputs that the surrounding register bank drives, and they may change between chips. The strip position is counted inside the block and wraps at the end of each chip, so no cluster ever joins two chips.

A record is only written when the FIFO reports enough free bytes for all of it. Otherwise the whole cluster is discarded and a sticky overflow flag rises. While a record is being written, the block stops taking strips.

Top module: `strip_cluster_finder`

## Requirements
- R1: A run of two or more adjacent strips, each with 4*signal > thrLow*noise (signed signal, strict compare, so a signal at or below zero never passes), is kept whole. A run may be as wide as the full chip.
- R2: A run of exactly one strip is kept only if 4*signal > thrHigh*noise. Otherwise it produces no output at all.
- R3: Both thresholds are sampled with each accepted strip, so a new threshold value changes the result for the strips that follow it.
- R4: The amplitude byte stored for a kept strip is its signal when that is below 255, and 255 otherwise.
- R5: A record is byte 0 = first strip index within the chip, byte 1 = width, then one amplitude byte per strip in increasing strip order. Its bytes appear on wrData with wrEn high on consecutive cycles.
- R6: A run still open at the chip's last strip is closed there. The strip position then returns to 0, and strip 0 of the next chip always opens a new run.
- R7: A kept cluster is written only if wrRoom >= width + 2. Otherwise no byte of it is written and overflowFlag is set, and the flag stays set until reset.
- R8: inReady is low for exactly the cycles in which a record is written, starting the cycle after the strip that closed the cluster. A strip is consumed only on a cycle with inValid and inReady both high.
- R9: After reset, inReady is 1, wrEn is 0, overflowFlag is 0 and the next strip consumed is strip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A strip value is present |
| inReady | output | 1 | Block takes the present strip this cycle |
| inSignal | input | SIG_W | Signed corrected strip amplitude |
| inNoise | input | NOISE_W | Unsigned noise of the same strip |
| thrLow | input | THR_W | Neighbour cut, two fractional bits |
| thrHigh | input | THR_W | Lone-strip cut, two fractional bits |
| wrRoom | input | ROOM_W | Free bytes in the FIFO |
| wrEn | output | 1 | FIFO write strobe |
| wrData | output | AMP_W | FIFO write byte |
| overflowFlag | output | 1 | Sticky: a kept cluster was dropped |

## Verification
The bench builds the block with NUM_STRIPS = 16 and FIFO_BYTES = 64, keeping the other widths at their defaults. The short chip lets a cluster run through the last strip and lets a cluster fill the whole chip in a few dozen cycles. It also lets chip after chip test the wrap of the strip position. The small FIFO room field lets the bench offer exactly width + 2 free bytes and one byte fewer, and it can drain the room to zero within a single chip.

// File: rtl/strip_clus_pkg.sv
package strip_clus_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_EMIT
  } clusState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWrite;   // store compressed amplitude of accepted passing strip
    logic emitStart;  // put first-strip index on the write bus
    logic emitWidth;  // put width on the write bus
    logic emitBody;   // put one stored amplitude on the write bus
  } clusStrobe_t;

endpackage

// File: rtl/strip_clus_datapath.sv
module strip_clus_datapath
  import strip_clus_pkg::*;
#(
  parameter int NUM_STRIPS = 128,
  parameter int SIG_W      = 12,
  parameter int NOISE_W    = 8,
  parameter int THR_W      = 8,
  parameter int FRAC_W     = 2,
  parameter int AMP_W      = 8,
  parameter int IDX_W      = $clog2(NUM_STRIPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SIG_W-1:0]   inSignal,
  input  logic [NOISE_W-1:0] inNoise,
  input  logic [THR_W-1:0]   thrLow,
  input  logic [THR_W-1:0]   thrHigh,
  output logic               passLow,
  output logic               passHigh,
  input  clusStrobe_t        strobe,
  input  logic [IDX_W-1:0]   bufWrAddr,
  input  logic [IDX_W-1:0]   bufRdAddr,
  input  logic [AMP_W-1:0]   hdrStart,
  input  logic [AMP_W-1:0]   hdrWidth,
  output logic               wrEn,
  output logic [AMP_W-1:0]   wrData
);

  localparam int SCL_W   = SIG_W + FRAC_W;
  localparam int PRD_W   = THR_W + NOISE_W;
  localparam int CMP_W   = ((SCL_W > PRD_W + 1) ? SCL_W : PRD_W + 1) + 1;
  localparam int AMP_MAX = (1 << AMP_W) - 1;

  // scaled signal compared against threshold times noise, no division
  logic signed [SCL_W-1:0] sigScaled;
  logic signed [CMP_W-1:0] sigCmp;
  logic [PRD_W-1:0]        prodLow;
  logic [PRD_W-1:0]        prodHigh;
  logic signed [CMP_W-1:0] lowCmp;
  logic signed [CMP_W-1:0] highCmp;

  always_comb begin
    sigScaled = $signed({inSignal, {FRAC_W{1'b0}}});
    sigCmp    = CMP_W'(sigScaled);
    prodLow   = PRD_W'(thrLow) * PRD_W'(inNoise);
    prodHigh  = PRD_W'(thrHigh) * PRD_W'(inNoise);
    lowCmp    = $signed(CMP_W'(prodLow));
    highCmp   = $signed(CMP_W'(prodHigh));
    passLow   = sigCmp > lowCmp;
    passHigh  = sigCmp > highCmp;
  end

  // saturating compression; only positive values reach the buffer
  logic [AMP_W-1:0] ampByte;
  always_comb begin
    if (inSignal[SIG_W-1])
      ampByte = '0;
    else if (inSignal[SIG_W-2:0] >= (SIG_W-1)'(AMP_MAX))
      ampByte = AMP_W'(AMP_MAX);
    else
      ampByte = inSignal[AMP_W-1:0];
  end

  // per-run amplitude store, indexed by position inside the run
  logic [AMP_W-1:0] clusterBuf [NUM_STRIPS];

  always_ff @(posedge clk) begin
    if (strobe.bufWrite)
      clusterBuf[bufWrAddr] <= ampByte;
  end

  always_comb begin
    wrEn = strobe.emitStart | strobe.emitWidth | strobe.emitBody;
    if (strobe.emitStart)
      wrData = hdrStart;
    else if (strobe.emitWidth)
      wrData = hdrWidth;
    else if (strobe.emitBody)
      wrData = clusterBuf[bufRdAddr];
    else
      wrData = '0;
  end

  // R1
  buf_write_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bufWrite |-> passLow);

  // R5
  emit_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.emitStart, strobe.emitWidth, strobe.emitBody}));

  // R8
  no_store_while_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.bufWrite && wrEn));

endmodule

// File: rtl/strip_clus_ctrl.sv
module strip_clus_ctrl
  import strip_clus_pkg::*;
#(
  parameter int NUM_STRIPS = 128,
  parameter int AMP_W      = 8,
  parameter int ROOM_W     = 12,
  parameter int IDX_W      = $clog2(NUM_STRIPS),
  parameter int LEN_W      = $clog2(NUM_STRIPS + 1),
  parameter int CNT_W      = $clog2(NUM_STRIPS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              passLow,
  input  logic              passHigh,
  input  logic [ROOM_W-1:0] wrRoom,
  output clusStrobe_t       strobe,
  output logic [IDX_W-1:0]  bufWrAddr,
  output logic [IDX_W-1:0]  bufRdAddr,
  output logic [AMP_W-1:0]  hdrStart,
  output logic [AMP_W-1:0]  hdrWidth,
  output logic              overflowFlag
);

  localparam int CMP_W = ((ROOM_W > LEN_W) ? ROOM_W : LEN_W) + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STRIPS - 1);

  clusState_e       state;
  logic [IDX_W-1:0] stripIdx;
  logic [LEN_W-1:0] runLen;
  logic [IDX_W-1:0] runStart;
  logic             runHigh;
  logic [IDX_W-1:0] emitStartR;
  logic [LEN_W-1:0] emitWidthR;
  logic [CNT_W-1:0] byteCnt;
  logic             overflowR;

  logic             accept;
  logic             lastStrip;
  logic             closing;
  logic [LEN_W-1:0] closeW;
  logic [IDX_W-1:0] closeStart;
  logic             closeHigh;
  logic             keep;
  logic             roomOk;
  logic             emitDone;

  always_comb begin
    accept     = inValid && (state == ST_IDLE);
    lastStrip  = (stripIdx == LAST_IDX);
    closeW     = passLow ? (runLen + LEN_W'(1)) : runLen;
    closing    = accept && (passLow ? lastStrip : (runLen != '0));
    closeStart = (runLen == '0) ? stripIdx : runStart;
    closeHigh  = (runLen == '0) ? passHigh : runHigh;
    keep       = (closeW >= LEN_W'(2)) || closeHigh;
    roomOk     = CMP_W'(wrRoom) >= (CMP_W'(closeW) + CMP_W'(2));
    emitDone   = (byteCnt == (CNT_W'(emitWidthR) + CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      stripIdx   <= '0;
      runLen     <= '0;
      runStart   <= '0;
      runHigh    <= 1'b0;
      emitStartR <= '0;
      emitWidthR <= '0;
      byteCnt    <= '0;
      overflowR  <= 1'b0;
    end else begin
      if (accept) begin
        stripIdx <= lastStrip ? '0 : stripIdx + IDX_W'(1);
        if (closing) begin
          runLen <= '0;
          if (keep && roomOk) begin
            state      <= ST_EMIT;
            emitStartR <= closeStart;
            emitWidthR <= closeW;
            byteCnt    <= '0;
          end else if (keep) begin
            overflowR <= 1'b1;
          end
        end else if (passLow) begin
          runLen <= runLen + LEN_W'(1);
          if (runLen == '0) begin
            runStart <= stripIdx;
            runHigh  <= passHigh;
          end
        end
      end
      if (state == ST_EMIT) begin
        byteCnt <= byteCnt + CNT_W'(1);
        if (emitDone)
          state <= ST_IDLE;
      end
    end
  end

  always_comb begin
    inReady          = (state == ST_IDLE);
    strobe.bufWrite  = accept && passLow;
    strobe.emitStart = (state == ST_EMIT) && (byteCnt == CNT_W'(0));
    strobe.emitWidth = (state == ST_EMIT) && (byteCnt == CNT_W'(1));
    strobe.emitBody  = (state == ST_EMIT) && (byteCnt >= CNT_W'(2));
    bufWrAddr        = IDX_W'(runLen);
    bufRdAddr        = IDX_W'(byteCnt - CNT_W'(2));
    hdrStart         = AMP_W'(emitStartR);
    hdrWidth         = AMP_W'(emitWidthR);
    overflowFlag     = overflowR;
  end

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowR |=> overflowR);

  // R5
  byte_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT) |-> (byteCnt <= (CNT_W'(emitWidthR) + CNT_W'(1))));

  // R6
  chip_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT) |-> ((int'(emitStartR) + int'(emitWidthR)) <= NUM_STRIPS));

  // R6
  fresh_chip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stripIdx == '0) |-> (runLen == '0));

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid));

endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import strip_clus_pkg::*;
#(
  parameter int NUM_STRIPS = 128,
  parameter int SIG_W      = 12,
  parameter int NOISE_W    = 8,
  parameter int THR_W      = 8,
  parameter int FRAC_W     = 2,
  parameter int AMP_W      = 8,
  parameter int FIFO_BYTES = 2048,
  localparam int ROOM_W    = $clog2(FIFO_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [SIG_W-1:0]   inSignal,
  input  logic [NOISE_W-1:0] inNoise,
  input  logic [THR_W-1:0]   thrLow,
  input  logic [THR_W-1:0]   thrHigh,
  input  logic [ROOM_W-1:0]  wrRoom,
  output logic               wrEn,
  output logic [AMP_W-1:0]   wrData,
  output logic               overflowFlag
);

  localparam int IDX_W = $clog2(NUM_STRIPS);
  localparam int LEN_W = $clog2(NUM_STRIPS + 1);
  localparam int CNT_W = $clog2(NUM_STRIPS + 2);

  clusStrobe_t      strobe;
  logic             passLow;
  logic             passHigh;
  logic [IDX_W-1:0] bufWrAddr;
  logic [IDX_W-1:0] bufRdAddr;
  logic [AMP_W-1:0] hdrStart;
  logic [AMP_W-1:0] hdrWidth;

  strip_clus_ctrl #(
    .NUM_STRIPS(NUM_STRIPS),
    .AMP_W     (AMP_W),
    .ROOM_W    (ROOM_W),
    .IDX_W     (IDX_W),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inReady     (inReady),
    .passLow     (passLow),
    .passHigh    (passHigh),
    .wrRoom      (wrRoom),
    .strobe      (strobe),
    .bufWrAddr   (bufWrAddr),
    .bufRdAddr   (bufRdAddr),
    .hdrStart    (hdrStart),
    .hdrWidth    (hdrWidth),
    .overflowFlag(overflowFlag)
  );

  strip_clus_datapath #(
    .NUM_STRIPS(NUM_STRIPS),
    .SIG_W     (SIG_W),
    .NOISE_W   (NOISE_W),
    .THR_W     (THR_W),
    .FRAC_W    (FRAC_W),
    .AMP_W     (AMP_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inSignal (inSignal),
    .inNoise  (inNoise),
    .thrLow   (thrLow),
    .thrHigh  (thrHigh),
    .passLow  (passLow),
    .passHigh (passHigh),
    .strobe   (strobe),
    .bufWrAddr(bufWrAddr),
    .bufRdAddr(bufRdAddr),
    .hdrStart (hdrStart),
    .hdrWidth (hdrWidth),
    .wrEn     (wrEn),
    .wrData   (wrData)
  );

endmodule

// File: tb/strip_cluster_finder_tb.sv
module strip_cluster_finder_tb;

  localparam int NS      = 16;
  localparam int FIFO_B  = 64;
  localparam int SIG_W   = 12;
  localparam int NOISE_W = 8;
  localparam int THR_W   = 8;
  localparam int AMP_W   = 8;
  localparam int ROOM_W  = $clog2(FIFO_B + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [SIG_W-1:0] inSignal = '0;
  logic [NOISE_W-1:0] inNoise = '0;
  logic [THR_W-1:0] thrLow = '0;
  logic [THR_W-1:0] thrHigh = '0;
  logic wrEn;
  logic [AMP_W-1:0] wrData;
  logic overflowFlag;
  int fifoRoom = FIFO_B;
  logic [ROOM_W-1:0] wrRoom;

  always #2.5 clk = ~clk;
  assign wrRoom = ROOM_W'(fifoRoom);

  strip_cluster_finder #(
    .NUM_STRIPS(NS), .SIG_W(SIG_W), .NOISE_W(NOISE_W), .THR_W(THR_W),
    .FRAC_W(2), .AMP_W(AMP_W), .FIFO_BYTES(FIFO_B)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSignal(inSignal), .inNoise(inNoise), .thrLow(thrLow), .thrHigh(thrHigh),
    .wrRoom(wrRoom), .wrEn(wrEn), .wrData(wrData), .overflowFlag(overflowFlag)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curTag = "R5";
  logic [7:0] expQ[$];
  int sigA[NS];
  int noiA[NS];
  bit expOvf = 0;
  int cycles = 0;

  // FIFO room model: a write consumes one byte
  always @(posedge clk) if (wrEn) fifoRoom <= fifoRoom - 1;

  task automatic check(input string tag, input bit ok, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected bytes and compare; records must be contiguous (R5, R8)
  int recPos = 0;
  int recRemain = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (recPos != 0 && !wrEn)
        check("R8", 1'b0, 0, 1, "write gap inside record");
      if (wrEn) begin
        check("R8", !inReady, int'(inReady), 0, "inReady during write");
        if (expQ.size() == 0) begin
          check(curTag, 1'b0, int'(wrData), -1, "unexpected byte");
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(curTag, wrData === e, int'(wrData), int'(e), "record byte");
        end
        if (recPos == 0) recPos = 1;
        else if (recPos == 1) begin
          recRemain = int'(wrData);
          recPos = (recRemain == 0) ? 0 : 2;
        end else begin
          recRemain--;
          if (recRemain == 0) recPos = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic clearChip();
    for (int i = 0; i < NS; i++) begin
      sigA[i] = 0;
      noiA[i] = 4;
    end
  endtask

  // build expected records straight from the requirement text
  task automatic pushRecord(input int start, input int width, input int tl, input int th, inout int room);
    bit lone;
    lone = (width == 1) && (sigA[start] * 4 > th * noiA[start]);
    if (width >= 2 || lone) begin
      if (room >= width + 2) begin
        room -= width + 2;
        expQ.push_back(8'(start));
        expQ.push_back(8'(width));
        for (int k = start; k < start + width; k++)
          expQ.push_back(sigA[k] >= 255 ? 8'd255 : 8'(sigA[k]));
      end else begin
        expOvf = 1;
      end
    end
  endtask

  task automatic runChip(input string tag, input int tl, input int th);
    int room;
    int runS;
    int runW;
    curTag = tag;
    @(negedge clk);
    thrLow = THR_W'(tl);
    thrHigh = THR_W'(th);
    room = fifoRoom;
    runW = 0;
    runS = 0;
    for (int i = 0; i < NS; i++) begin
      if (sigA[i] * 4 > tl * noiA[i]) begin
        if (runW == 0) runS = i;
        runW++;
      end else if (runW > 0) begin
        pushRecord(runS, runW, tl, th, room);
        runW = 0;
      end
    end
    if (runW > 0) pushRecord(runS, runW, tl, th, room);
    for (int i = 0; i < NS; i++) begin
      if (i % 5 == 3) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inSignal = SIG_W'(sigA[i]);
      inNoise = NOISE_W'(noiA[i]);
      while (!inReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (NS + 6) @(negedge clk);
    check(tag, expQ.size() == 0, expQ.size(), 0, "records left unwritten");
    check("R7", overflowFlag == expOvf, int'(overflowFlag), int'(expOvf), "overflow flag");
    check("R8", inReady == 1'b1, int'(inReady), 1, "ready after chip");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", inReady == 1'b1, int'(inReady), 1, "inReady in reset");
    check("R9", wrEn == 1'b0, int'(wrEn), 0, "wrEn in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R9", overflowFlag == 1'b0, int'(overflowFlag), 0, "overflow after reset");
    check("R9", wrEn == 1'b0, int'(wrEn), 0, "wrEn after reset");

    // R1 pair, R2 lone below and above high cut, R4 saturation, R6 close at last strip
    clearChip();
    sigA[2] = 20; sigA[3] = 30; sigA[6] = 20; sigA[9] = 40;
    sigA[12] = 300; sigA[13] = 13; sigA[14] = 255; sigA[15] = 254;
    runChip("R1", 12, 24);

    // R6 new chip starts fresh; equality boundaries, zero noise, negative strip (R2)
    clearChip();
    sigA[0] = 13; sigA[1] = 13; sigA[4] = 12; sigA[5] = 25; sigA[7] = 24;
    sigA[10] = 1; noiA[10] = 0; sigA[11] = 1; noiA[11] = 0;
    sigA[14] = -50; noiA[14] = 0; sigA[15] = 1; noiA[15] = 0;
    runChip("R2", 12, 24);

    // R3 same data as the first chip with raised thresholds
    clearChip();
    sigA[2] = 20; sigA[3] = 30; sigA[6] = 20; sigA[9] = 40;
    sigA[12] = 300; sigA[13] = 13; sigA[14] = 255; sigA[15] = 254;
    runChip("R3", 40, 80);

    // R1 and R6 cluster covering the whole chip
    clearChip();
    for (int i = 0; i < NS; i++) sigA[i] = 100;
    runChip("R6", 12, 24);

    // R7 room short by one byte, then exactly enough, then empty
    check("R7", overflowFlag == 1'b0, int'(overflowFlag), 0, "flag before drop");
    fifoRoom = 5;
    clearChip();
    sigA[1] = 30; sigA[2] = 30; sigA[3] = 30; sigA[4] = 30;
    sigA[8] = 30; sigA[9] = 30; sigA[10] = 30;
    sigA[13] = 50;
    runChip("R7", 12, 24);
    check("R7", fifoRoom == 0, fifoRoom, 0, "room used by accepted record");

    // R7 flag stays set; R4 compression of a mid value
    fifoRoom = FIFO_B;
    clearChip();
    sigA[0] = 60;
    runChip("R4", 12, 24);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule